// File: doc/BRIEF.md
# Input Change Interrupt Monitor

This block watches a set of synchronized pin levels, grouped into banks of equal width, and raises an interrupt flag whenever a pin that is configured as an input no longer matches a stored comparison copy of its level. The comparison copy (the snapshot) is refreshed bank by bank whenever software reads that bank's input register. A configuration write refreshes every bank at once. Because the flag is a level comparison and not a latched edge, it drops by itself as soon as every monitored pin is back at its snapshot value.

The flag is offered as a status bit and also drives a shared active-low pin. When interrupt mode is enabled, the pin is pulled low while the flag is set. When interrupt mode is disabled, the pin carries a general-purpose output value instead. A bank read also returns that bank's live pin levels on a read-data port one cycle later, for input pins and output pins alike. All ports are plain control and status signals. The strobes carry no handshake and are taken in the cycle in which they are high, so no back-pressure exists. Synchronizers sit upstream and the pin drivers sit downstream. Reset is synchronous and active low, and during reset every snapshot is loaded from the live levels.

Top module: `pin_change_irq`

## Requirements
- R1: While reset is held, every snapshot is loaded from the live pin levels. After release, static pins leave `irq_flag` at 0 and `read_data` at 0.
- R2: If an input-configured pin (`pin_is_input` bit = 1) differs from its snapshot at a clock edge, `irq_flag` is 1 after that edge.
- R3: Pins with `pin_is_input` bit = 0 never affect `irq_flag`, whatever their level.
- R4: When every input-configured pin matches its snapshot again at an edge, `irq_flag` is 0 after that edge, and no read is needed.
- R5: A high `bank_read[b]` at an edge loads the snapshot of bank b (pins b*BANK_W to b*BANK_W+BANK_W-1) only. Mismatches in other banks keep the flag set.
- R6: A high `cfg_write` at an edge loads the snapshots of all banks, so `irq_flag` is 0 after that edge.
- R7: With `irq_enable` = 1, `irq_pin_n` is the inverse of `irq_flag`. With `irq_enable` = 0, `irq_pin_n` equals `gpo_value`.
- R8: On an edge where any `bank_read` bit is high, `read_data` takes the live levels of the lowest-numbered selected bank, regardless of direction. With no strobe high, it holds its value.
- R9: Turning a pin from output to input while its level differs from its snapshot sets `irq_flag` after the next edge. No masking is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_level | input | NUM_BANKS*BANK_W | Synchronized live pin levels |
| pin_is_input | input | NUM_BANKS*BANK_W | Direction per pin, 1 = input |
| bank_read | input | NUM_BANKS | Per-bank input register read strobe |
| cfg_write | input | 1 | Configuration write strobe |
| irq_enable | input | 1 | 1 = shared pin shows interrupt, 0 = general output |
| gpo_value | input | 1 | Level for the shared pin in general output mode |
| irq_flag | output | 1 | Interrupt status flag |
| irq_pin_n | output | 1 | Shared active-low interrupt / general output pin |
| read_data | output | BANK_W | Live levels captured by the last bank read |

## Verification
The bench uses the default shape of two banks of eight pins. This is the smallest shape in which a read of one bank can be seen to leave a mismatch in the other bank pending. It also makes the lowest-bank priority on simultaneous read strobes observable. Sparse random pin flips, direction changes and strobes then reach the cases where the flag persists across reads, clears by itself, and reappears after direction changes.

// File: rtl/pin_change_irq_pkg.sv
package pin_change_irq_pkg;

  // Width of a bank index for a given bank count (at least 1 bit).
  function automatic int bank_idx_w(input int nbanks);
    int w;
    w = 1;
    while ((1 << w) < nbanks) w++;
    return w;
  endfunction

endpackage

// File: rtl/pci_bank_snap.sv
module pci_bank_snap #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] live,
  input  logic [W-1:0] is_in,
  input  logic         refresh,
  output logic         diff_next
);

  logic [W-1:0] snap_q;
  logic [W-1:0] snap_d;
  logic [W-1:0] miss;

  // Snapshot reloads on reset or on any refresh request.
  always_comb begin
    snap_d = snap_q;
    if (!rst_n || refresh) snap_d = live;
  end

  always_ff @(posedge clk) begin
    snap_q <= snap_d;
  end

  // Compare against the snapshot that will hold after this edge.
  assign miss      = (live ^ snap_d) & is_in;
  assign diff_next = |miss;

endmodule

// File: rtl/pci_flag_reg.sv
module pci_flag_reg #(
  parameter int NB = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] bank_diff,
  output logic          flag
);

  logic flag_q;

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= |bank_diff;
  end

  assign flag = flag_q;

endmodule

// File: rtl/pci_rd_capture.sv
module pci_rd_capture #(
  parameter int NB = 2,
  parameter int W  = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NB*W-1:0] live,
  input  logic [NB-1:0]   sel,
  output logic [W-1:0]    data
);

  logic [W-1:0] pick;
  logic [W-1:0] data_q;

  // Lowest selected bank wins: scan from the top so low indices overwrite.
  always_comb begin
    pick = data_q;
    for (int b = NB - 1; b >= 0; b--) begin
      if (sel[b]) pick = live[b*W +: W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) data_q <= '0;
    else        data_q <= pick;
  end

  assign data = data_q;

endmodule

// File: rtl/pin_change_irq.sv
module pin_change_irq
  import pin_change_irq_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_level,
  input  logic [NUM_BANKS*BANK_W-1:0] pin_is_input,
  input  logic [NUM_BANKS-1:0]        bank_read,
  input  logic                        cfg_write,
  input  logic                        irq_enable,
  input  logic                        gpo_value,
  output logic                        irq_flag,
  output logic                        irq_pin_n,
  output logic [BANK_W-1:0]           read_data
);

  localparam int NPINS = NUM_BANKS * BANK_W;
  localparam int IDXW  = bank_idx_w(NUM_BANKS);

  logic [NUM_BANKS-1:0] bank_diff;
  logic                 flag_w;

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    pci_bank_snap #(.W(BANK_W)) u_snap (
      .clk      (clk),
      .rst_n    (rst_n),
      .live     (pin_level[g*BANK_W +: BANK_W]),
      .is_in    (pin_is_input[g*BANK_W +: BANK_W]),
      .refresh  (bank_read[g] | cfg_write),
      .diff_next(bank_diff[g])
    );
  end

  pci_flag_reg #(.NB(NUM_BANKS)) u_flag (
    .clk      (clk),
    .rst_n    (rst_n),
    .bank_diff(bank_diff),
    .flag     (flag_w)
  );

  pci_rd_capture #(.NB(NUM_BANKS), .W(BANK_W)) u_rd (
    .clk  (clk),
    .rst_n(rst_n),
    .live (pin_level),
    .sel  (bank_read),
    .data (read_data)
  );

  assign irq_flag  = flag_w;
  assign irq_pin_n = irq_enable ? ~flag_w : gpo_value;

  // Elaboration-time sanity on the shape.
  initial begin
    if (NPINS < 1 || IDXW < 1) $error("pin_change_irq: bad shape");
  end

endmodule

// File: rtl/pin_change_irq_chk.sv
module pin_change_irq_chk #(
  parameter int NUM_BANKS = 2,
  parameter int BANK_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [NUM_BANKS*BANK_W-1:0] pin_is_input,
  input logic [NUM_BANKS-1:0]        bank_read,
  input logic                        cfg_write,
  input logic                        irq_enable,
  input logic                        gpo_value,
  input logic                        irq_flag,
  input logic                        irq_pin_n,
  input logic [BANK_W-1:0]           read_data
);

  AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_write |=> !irq_flag) else $error("cfg write left flag set"); // R6

  AST_ALL_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (&bank_read) |=> !irq_flag) else $error("full read left flag set"); // R5

  AST_NO_INPUTS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_is_input == '0) |=> !irq_flag) else $error("output pins raised flag"); // R3

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bank_read == '0) |=> $stable(read_data)) else $error("read data moved"); // R8

  AST_PIN_IRQ_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_enable && irq_flag) |-> !irq_pin_n) else $error("pin not asserted"); // R7

  AST_PIN_GPO_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_enable |-> (irq_pin_n == gpo_value)) else $error("gpo mismatch"); // R7

endmodule

bind pin_change_irq pin_change_irq_chk #(
  .NUM_BANKS(NUM_BANKS),
  .BANK_W   (BANK_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pin_is_input(pin_is_input),
  .bank_read   (bank_read),
  .cfg_write   (cfg_write),
  .irq_enable  (irq_enable),
  .gpo_value   (gpo_value),
  .irq_flag    (irq_flag),
  .irq_pin_n   (irq_pin_n),
  .read_data   (read_data)
);

// File: tb/pin_change_irq_tb.sv
module pin_change_irq_tb;

  localparam int NB = 2;
  localparam int W  = 8;
  localparam int N  = NB * W;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [N-1:0]  pin_level;
  logic [N-1:0]  pin_is_input;
  logic [NB-1:0] bank_read;
  logic          cfg_write;
  logic          irq_enable;
  logic          gpo_value;
  logic          irq_flag;
  logic          irq_pin_n;
  logic [W-1:0]  read_data;

  int checks = 0;
  int fails  = 0;

  logic [N-1:0] m_snap;
  logic         m_flag;
  logic [W-1:0] m_rd;

  always #5 clk = ~clk;

  pin_change_irq #(.NUM_BANKS(NB), .BANK_W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .pin_level(pin_level), .pin_is_input(pin_is_input),
    .bank_read(bank_read), .cfg_write(cfg_write), .irq_enable(irq_enable),
    .gpo_value(gpo_value), .irq_flag(irq_flag), .irq_pin_n(irq_pin_n),
    .read_data(read_data)
  );

  function automatic logic exp_pin();
    return irq_enable ? ~m_flag : gpo_value;
  endfunction

  // Model of one clock edge, from the requirements.
  function automatic void model_edge();
    logic done;
    if (!rst_n) begin
      m_snap = pin_level; m_flag = 1'b0; m_rd = '0;         // R1
      return;
    end
    done = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (bank_read[b] || cfg_write)                          // R5 R6
        m_snap[b*W +: W] = pin_level[b*W +: W];
      if (bank_read[b] && !done) begin                        // R8
        m_rd = pin_level[b*W +: W];
        done = 1'b1;
      end
    end
    m_flag = |((pin_level ^ m_snap) & pin_is_input);          // R2 R3 R4 R9
  endfunction

  task automatic tick();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    bank_read = '0;
    cfg_write = 1'b0;
  endtask

  task automatic check1(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_all(input string req);
    check1({req, " flag"}, {7'd0, irq_flag}, {7'd0, m_flag});
    check1({req, " pin"}, {7'd0, irq_pin_n}, {7'd0, exp_pin()});
    check1({req, " rd"}, read_data, m_rd);
  endtask

  initial begin : watchdog
    #1500000;
    fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin : stim
    void'($urandom(32'd1234));
    rst_n = 1'b0; pin_level = 16'hA5A5; pin_is_input = '1;
    bank_read = '0; cfg_write = 1'b0; irq_enable = 1'b1; gpo_value = 1'b0;
    @(negedge clk);
    tick(); tick();
    rst_n = 1'b1;
    tick(); check_all("R1");
    check1("R1 flag low", {7'd0, irq_flag}, 8'd0);

    pin_level[3] = ~pin_level[3];
    tick(); check_all("R2");
    check1("R2 flag high", {7'd0, irq_flag}, 8'd1);
    check1("R7 pin low", {7'd0, irq_pin_n}, 8'd0);

    pin_level[3] = ~pin_level[3];
    tick(); check_all("R4");
    check1("R4 self clear", {7'd0, irq_flag}, 8'd0);

    pin_is_input[3] = 1'b0; pin_level[3] = ~pin_level[3];
    tick(); check_all("R3");
    check1("R3 output ignored", {7'd0, irq_flag}, 8'd0);

    pin_is_input[3] = 1'b1;
    tick(); check_all("R9");
    check1("R9 dir switch", {7'd0, irq_flag}, 8'd1);

    pin_level[12] = ~pin_level[12];
    bank_read = 2'b01;
    tick(); check_all("R5");
    check1("R5 other bank pending", {7'd0, irq_flag}, 8'd1);
    check1("R8 bank0 data", read_data, pin_level[7:0]);
    bank_read = 2'b10;
    tick(); check_all("R5");
    check1("R5 cleared", {7'd0, irq_flag}, 8'd0);

    pin_level = pin_level ^ 16'h0101;
    tick(); check_all("R2");
    cfg_write = 1'b1;
    tick(); check_all("R6");
    check1("R6 cleared", {7'd0, irq_flag}, 8'd0);

    irq_enable = 1'b0; gpo_value = 1'b1;
    tick(); check_all("R7");
    gpo_value = 1'b0;
    tick(); check_all("R7");
    irq_enable = 1'b1;

    pin_is_input = 16'h0F0F; pin_level = 16'h3C5A;
    bank_read = 2'b11;
    tick(); check_all("R8");
    check1("R8 priority", read_data, 8'h5A);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[3:0] == 4'd0) pin_level[r[11:8]] = ~pin_level[r[11:8]];
      if (r[7:4] == 4'd1) pin_is_input[r[15:12]] = ~pin_is_input[r[15:12]];
      if (r[19:16] == 4'd2) bank_read = r[21:20];
      if (r[27:22] == 6'd3) cfg_write = 1'b1;
      if (r[31:28] == 4'd4) irq_enable = ~irq_enable;
      gpo_value = r[24];
      tick();
      check_all("R2 R4 R5 R7 R8 random");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule